// File: doc/BRIEF.md
# Embedded-Clock Word Serializer

This block turns a 10-bit parallel word (one data byte plus two control bits) into a single serial bitstream. It sends 12 bits per word period. Each word is wrapped in a 12-bit frame. The frame opens with a one bit and closes with a zero bit. These two embedded clock bits guarantee that the line toggles in every frame, whatever the payload is.

Everything runs on one bit-rate clock, 12 times the rate of the parallel clock. The parallel clock enters as an ordinary input and is sampled on the bit clock. A word is captured on the parallel-clock edge chosen by a select pin, either rising or falling. The most recently captured word goes into the next frame.

A sync request replaces the data frame with a fixed training pattern so that a receiver can lock quickly. A driver-enable output tells the pad driver when to go to high impedance. A powerdown input clears the shifter and quiets the block. The PLL, the line driver and the electrical levels lie outside this block.

Top module: `ecs_serializer`

## Requirements
- R1: A data frame, in transmission order, is: bit 0 = 1 (start), bits 1 to 10 = data_i bits 0 to 9 (LSB first), bit 11 = 0 (stop). The frame appears on ser_o one bit per clock.
- R2: Frames follow each other with no gap, 12 bit clocks apart. The first frame loads on the first clock edge after reset or powerdown is released, so its bit 0 is on ser_o during the following cycle.
- R3: Every frame on ser_o contains at least one 0 and at least one 1.
- R4: If sync_i is high at the edge where a frame loads, that frame is six 1s followed by six 0s in transmission order.
- R5: With edge_sel_i = 0, data_i is captured on a rising edge of pclk_i. With edge_sel_i = 1, it is captured on a falling edge. A pclk_i edge of the other polarity captures nothing. A data frame carries the word captured most recently before its load edge. Capture continues while sync frames are sent.
- R6: While oe_i is low, ser_oe_o is low. Shifting continues unchanged, so frames stay aligned when oe_i returns high.
- R7: From the first clock edge with pd_i high, ser_o and ser_oe_o are 0 and the shift register is cleared. pclk_i edges during powerdown capture nothing, and the held word is kept. After release, a full frame starts as described in R2.
- R8: During reset, ser_o and ser_oe_o are 0. The held word resets to zero, so the first frame carries word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pclk_i | input | 1 | Parallel word clock, sampled on clk_i |
| edge_sel_i | input | 1 | Capture edge: 0 = rising, 1 = falling |
| data_i | input | 10 | Parallel word: byte plus two control bits |
| sync_i | input | 1 | Send the training pattern instead of data |
| oe_i | input | 1 | Serial driver enable request |
| pd_i | input | 1 | Powerdown |
| ser_o | output | 1 | Serial bit |
| ser_oe_o | output | 1 | Driver enable; 0 means the line is high impedance |

## Verification
The bench drives the opposite-polarity pclk_i edge with the complement of the word. A design that ignores edge_sel_i would therefore send inverted payloads. It checks the all-ones and all-zero words, where only the start and stop bits supply transitions. A frame with swapped or missing clock bits would then show no toggle. Back-to-back sync frames and the return to data test the selection made at the load edge. Dropping oe_i tests that alignment is kept. A powerdown in the middle of a frame, with pclk_i edges arriving during it, tests the clearing of the shifter, the full frame after release and the held word. A design that kept shifting, resumed in mid-frame or captured during powerdown would produce the wrong bits.

// File: rtl/ecs_pkg.sv
package ecs_pkg;
  localparam int unsigned WORD_W_DEF = 10;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_sel_e;
endpackage

// File: rtl/ecs_capture.sv
module ecs_capture #(
  parameter int unsigned W = ecs_pkg::WORD_W_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         pclk_i,
  input  logic         edge_sel_i,
  input  logic         pd_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] word_o
);
  import ecs_pkg::*;

  logic         pclk_q;
  logic [W-1:0] word_q;
  logic         rise, fall, take;
  edge_sel_e    sel;

  assign sel  = edge_sel_e'(edge_sel_i);
  assign rise = pclk_i & ~pclk_q;
  assign fall = ~pclk_i & pclk_q;
  assign take = ~pd_i & ((sel == EDGE_FALL) ? fall : rise);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pclk_q <= 1'b0;
      word_q <= '0;
    end else begin
      pclk_q <= pclk_i;
      if (take) word_q <= data_i;
    end
  end

  assign word_o = word_q;

  p_capture_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pd_i && !edge_sel_i && $rose(pclk_i)) |=> (word_o == $past(data_i)));

  p_capture_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pd_i && edge_sel_i && $fell(pclk_i)) |=> (word_o == $past(data_i)));

  p_hold_in_pd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_i |=> $stable(word_o));
endmodule

// File: rtl/ecs_framer.sv
module ecs_framer #(
  parameter int unsigned W  = ecs_pkg::WORD_W_DEF,
  parameter int unsigned FW = W + 2
) (
  input  logic [W-1:0]  word_i,
  input  logic          sync_i,
  output logic [FW-1:0] frame_o
);
  logic [FW-1:0] sync_pat;

  // training pattern: lower half ones (sent first), upper half zeros
  for (genvar i = 0; i < FW; i++) begin : g_sync
    assign sync_pat[i] = (i < FW / 2);
  end

  assign frame_o = sync_i ? sync_pat : {1'b0, word_i, 1'b1};
endmodule

// File: rtl/ecs_shifter.sv
module ecs_shifter #(
  parameter int unsigned FW = ecs_pkg::WORD_W_DEF + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pd_i,
  input  logic [FW-1:0] frame_i,
  output logic          load_o,
  output logic          bit_o,
  output logic          drv_o
);
  localparam int unsigned CW = $clog2(FW);
  localparam logic [CW-1:0] LAST = CW'(FW - 1);

  logic [CW-1:0] cnt_q;
  logic [FW-1:0] sh_q;
  logic          drv_q;
  logic          load;

  assign load = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= LAST;
      sh_q  <= '0;
      drv_q <= 1'b0;
    end else if (pd_i) begin
      cnt_q <= LAST;
      sh_q  <= '0;
      drv_q <= 1'b0;
    end else if (load) begin
      cnt_q <= '0;
      sh_q  <= frame_i;
      drv_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      sh_q  <= sh_q >> 1;
    end
  end

  assign load_o = load & ~pd_i;
  assign bit_o  = sh_q[0];
  assign drv_o  = drv_q;

  // checker state: levels seen so far in the current frame
  logic seen_hi_q, seen_lo_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_hi_q <= 1'b0;
      seen_lo_q <= 1'b0;
    end else if (pd_i || load) begin
      seen_hi_q <= 1'b0;
      seen_lo_q <= 1'b0;
    end else begin
      seen_hi_q <= seen_hi_q | sh_q[0];
      seen_lo_q <= seen_lo_q | ~sh_q[0];
    end
  end

  p_frame_toggle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && drv_q && !pd_i) |-> ((seen_hi_q || sh_q[0]) && (seen_lo_q || !sh_q[0])));

  p_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && !pd_i) |=> (cnt_q == '0));

  p_pd_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_i |=> (sh_q == '0 && !drv_q && cnt_q == LAST));
endmodule

// File: rtl/ecs_serializer.sv
module ecs_serializer #(
  parameter int unsigned WORD_W = ecs_pkg::WORD_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pclk_i,
  input  logic              edge_sel_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              sync_i,
  input  logic              oe_i,
  input  logic              pd_i,
  output logic              ser_o,
  output logic              ser_oe_o
);
  localparam int unsigned FW = WORD_W + 2;

  logic [WORD_W-1:0] word;
  logic [FW-1:0]     frame;
  logic              load, drv;

  ecs_capture #(.W(WORD_W)) u_capture (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pclk_i     (pclk_i),
    .edge_sel_i (edge_sel_i),
    .pd_i       (pd_i),
    .data_i     (data_i),
    .word_o     (word)
  );

  ecs_framer #(.W(WORD_W), .FW(FW)) u_framer (
    .word_i  (word),
    .sync_i  (sync_i),
    .frame_o (frame)
  );

  ecs_shifter #(.FW(FW)) u_shifter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pd_i    (pd_i),
    .frame_i (frame),
    .load_o  (load),
    .bit_o   (ser_o),
    .drv_o   (drv)
  );

  assign ser_oe_o = drv & oe_i;

  p_start_bit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && !sync_i) |=> ser_o);

  p_sync_lead_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && sync_i) |=> ser_o);

  p_pd_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(pd_i) |-> (!ser_o && !ser_oe_o));

  p_reset_quiet_r8: assert property (@(posedge clk_i)
    !rst_ni |-> (!ser_o && !ser_oe_o));
endmodule

// File: tb/ecs_serializer_tb.sv
module ecs_serializer_tb;
  logic       clk = 1'b0;
  logic       rst_n, pclk, es, sync, oe, pd;
  logic [9:0] data;
  logic       ser, ser_oe;
  int         total = 0;
  int         bad = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  ecs_serializer u_dut (
    .clk_i (clk), .rst_ni (rst_n), .pclk_i (pclk), .edge_sel_i (es),
    .data_i (data), .sync_i (sync), .oe_i (oe), .pd_i (pd),
    .ser_o (ser), .ser_oe_o (ser_oe)
  );

  typedef struct packed {
    logic [9:0] word;
    logic       fall;
    logic       syn;
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    {10'h3FF, 1'b0, 1'b0},
    {10'h000, 1'b1, 1'b0},
    {10'h2AA, 1'b0, 1'b0},
    {10'h155, 1'b1, 1'b0},
    {10'h0F0, 1'b0, 1'b1},
    {10'h301, 1'b0, 1'b1},
    {10'h001, 1'b1, 1'b0},
    {10'h200, 1'b0, 1'b0}
  };

  localparam logic [11:0] SYNC_F = 12'h03F;

  function automatic logic [11:0] data_frame(input logic [9:0] w);
    return {1'b0, w, 1'b1};
  endfunction

  task automatic check(input bit ok, input string req, input logic [11:0] got,
                       input logic [11:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // collect one frame; drives a pclk period carrying d on the selected edge
  task automatic frame_cycle(input logic [9:0] d, input logic fall, input logic syn,
                             output logic [11:0] f, output int oe_cnt);
    oe_cnt = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      f[i] = ser;
      if (ser_oe) oe_cnt++;
      if (i == 0) begin es = fall; sync = syn; end
      if (i == 2) begin pclk = 1'b1; data = fall ? ~d : d; end
      if (i == 7) begin pclk = 1'b0; data = fall ? d : ~d; end
    end
  endtask

  initial begin
    logic [11:0] got, exp;
    int          n;
    rst_n = 1'b0; pclk = 1'b0; es = 1'b0; sync = 1'b0; oe = 1'b1; pd = 1'b0;
    data = '0;
    repeat (3) @(negedge clk);
    check(ser == 1'b0, "R8 ser in reset", {11'b0, ser}, 12'h0);
    check(ser_oe == 1'b0, "R8 oe in reset", {11'b0, ser_oe}, 12'h0);
    rst_n = 1'b1;
    exp = data_frame(10'h000);  // R8: first frame carries word zero

    foreach (VECS[k]) begin
      frame_cycle(VECS[k].word, VECS[k].fall, VECS[k].syn, got, n);
      check(got == exp, "R1/R4/R5/R8 frame", got, exp);
      check(got != 12'h000 && got != 12'hFFF, "R3 transition", got, exp);
      check(n == 12, "R2 driver on each bit", 12'(n), 12'd12);
      exp = VECS[k].syn ? SYNC_F : data_frame(VECS[k].word);
    end

    // R6: driver off, shifting keeps going
    oe = 1'b0;
    frame_cycle(10'h1C3, 1'b0, 1'b0, got, n);
    check(got == exp, "R6 frame while oe low", got, exp);
    check(n == 0, "R6 ser_oe_o low", 12'(n), 12'd0);
    exp = data_frame(10'h1C3);
    oe = 1'b1;
    frame_cycle(10'h0A5, 1'b1, 1'b0, got, n);
    check(got == exp && n == 12, "R6 alignment after oe", got, exp);
    exp = data_frame(10'h0A5);

    // R7: powerdown mid-frame; partial frame of 0A5 then edges during pd
    repeat (5) @(negedge clk);
    pd = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(ser == 1'b0 && ser_oe == 1'b0, "R7 quiet in powerdown",
            {10'b0, ser, ser_oe}, 12'h0);
      if (i == 1) begin pclk = 1'b1; data = 10'h3C3; end
      if (i == 3) begin pclk = 1'b0; data = 10'h111; end
    end
    pd = 1'b0;
    frame_cycle(10'h2D2, 1'b0, 1'b0, got, n);
    check(got == exp, "R7 full frame with held word after release", got, exp);
    check(n == 12, "R2 driver back after release", 12'(n), 12'd12);
    exp = data_frame(10'h2D2);
    frame_cycle(10'h0FF, 1'b0, 1'b0, got, n);
    check(got == exp, "R2 R5 next frame after release", got, exp);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule